// File: doc/BRIEF.md
# Triggered SPI Command Replay Sequencer

This block sits between a trigger source and a separate SPI execution unit. While it is disabled, a list of 16-bit controller commands and a list of outgoing data words are loaded into two small on-chip stores. Once it is enabled, each qualifying rising edge of the trigger replays the entire command list on a valid/ready command stream. At the same time, the block replays the data list on a valid/ready data stream. Read data returned by the execution unit is passed straight through to a DMA-bound output stream. Each finished replay publishes a transfer identifier on a status stream. The block then advances that identifier by one.

A small state machine controls the replay. It has three states. `ST_IDLE` waits for a start: trigger rising edge, enable high, DMA ready high, and at least one command stored. `ST_ISSUE` presents the stored entries and advances each read pointer only on a handshake. When both lists are fully accepted, it moves to `ST_FINISH`. `ST_FINISH` lasts one cycle. It loads the status register, bumps the identifier, clears the read pointers and returns to `ST_IDLE`. The trigger can go through an optional two-flop synchronizer, chosen by a parameter.

Top module: `spi_replay_seq`

## Requirements
- R1: A load strobe appends its word at the next free slot of its store only while `en` is low and no replay runs. Strobes while `en` is high or a replay runs are ignored. Strobes into a store already holding DEPTH entries are ignored.
- R2: After reset both stores are empty, the identifier is 0, and `cmd_valid`, `sdo_valid` and `stat_valid` are low. A trigger with an empty command store starts nothing.
- R3: A replay starts on a trigger rising edge seen in `ST_IDLE` with `en` and `dma_ready` high. Every stored command then appears on `cmd_data` exactly once, in load order.
- R4: During a replay every stored data word appears on `sdo_data` exactly once, in load order. The replay ends only after both lists are accepted.
- R5: A trigger edge seen while `dma_ready` is low starts no replay.
- R6: A trigger edge during a running replay is ignored, not queued.
- R7: With `en` low no replay starts. A replay already running when `en` falls completes in full.
- R8: A command with bits [15:12] equal to 4'h3 is a SYNC. When it is loaded, the identifier takes its bits [7:0]. The last SYNC loaded wins.
- R9: At the end of each replay, `stat_valid` rises with `stat_id` equal to the current identifier, and the identifier then increases by one. `stat_valid` holds until `stat_ready`.
- R10: While a replay runs, `dma_valid` follows `sdi_valid`, `dma_data` follows `sdi_data`, and `sdi_ready` follows `dma_ready`. While idle, `sdi_ready` is 1 and `dma_valid` is 0.
- R11: A read pointer advances only on a valid-and-ready handshake. `cmd_valid` and `cmd_data` stay stable while stalled.
- R12: With ASYNC_TRIG=1 (the default), the first `cmd_valid` appears at the third rising clock edge after the trigger is raised. With ASYNC_TRIG=0 it appears at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable for replays; loads allowed only when low |
| trig_in | input | 1 | External trigger, rising edge active |
| ld_cmd_valid | input | 1 | Command load strobe |
| ld_cmd_data | input | 16 | Command word to load |
| ld_sdo_valid | input | 1 | Data-word load strobe |
| ld_sdo_data | input | DW | Data word to load |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | 16 | Command stream word |
| sdo_valid | output | 1 | Outgoing data stream valid |
| sdo_ready | input | 1 | Outgoing data stream ready |
| sdo_data | output | DW | Outgoing data word |
| sdi_valid | input | 1 | Read data valid from execution unit |
| sdi_ready | output | 1 | Read data ready toward execution unit |
| sdi_data | input | DW | Read data word |
| dma_valid | output | 1 | DMA-bound stream valid |
| dma_ready | input | 1 | DMA-bound stream ready; also gates replay start |
| dma_data | output | DW | DMA-bound data word |
| stat_valid | output | 1 | Status stream valid |
| stat_ready | input | 1 | Status stream ready |
| stat_id | output | 8 | Identifier of the finished transfer |

## Verification
The bench goes after several corner cases:
- A second trigger during a stalled replay. A design that queued it would replay the list twice.
- Dropping enable mid-replay. A design that aborted would lose commands and never post a status.
- Loads while enabled. A design that accepted them would lengthen the list or change the identifier.
- Two SYNC commands in one list. A design that kept the first SYNC would report the wrong starting identifier.
- Overfilling a store. A design without a full check would wrap around and overwrite entries.

Random ready patterns on both output streams expose a pointer that advances without a handshake, which would skip or repeat words. A replay with more data words than commands shows whether a design ends early and truncates the data list.

// File: rtl/spi_replay_pkg.sv
package spi_replay_pkg;

    localparam int CMD_W   = 16;
    localparam int OPC_MSB = 15;
    localparam int OPC_LSB = 12;
    localparam int ID_W    = 8;
    localparam logic [OPC_MSB-OPC_LSB:0] OPC_SYNC = 4'h3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FINISH
    } rep_state_t;

    function automatic logic cmd_is_sync(input logic [CMD_W-1:0] c);
        return c[OPC_MSB:OPC_LSB] == OPC_SYNC;
    endfunction

endpackage

// File: rtl/replay_trig_detect.sv
module replay_trig_detect #(
    parameter bit ASYNC_TRIG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);

    logic trig_s;
    logic trig_prev_q;

    generate
        if (ASYNC_TRIG) begin : g_sync
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= trig_in;
                    stab_q <= meta_q;
                end
            end
            assign trig_s = stab_q;
        end else begin : g_direct
            assign trig_s = trig_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev_q <= 1'b0;
        else        trig_prev_q <= trig_s;
    end

    assign trig_rise = trig_s & ~trig_prev_q;

endmodule

// File: rtl/replay_store.sv
module replay_store
    import spi_replay_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             ld_cmd_valid,
    input  logic [CMD_W-1:0] ld_cmd_data,
    input  logic             ld_sdo_valid,
    input  logic [DW-1:0]    ld_sdo_data,
    input  logic [AW-1:0]    cmd_idx,
    input  logic [AW-1:0]    sdo_idx,
    input  logic             id_inc,
    output logic [CMD_W-1:0] cmd_word,
    output logic [DW-1:0]    sdo_word,
    output logic [CW-1:0]    cmd_cnt,
    output logic [CW-1:0]    sdo_cnt,
    output logic [ID_W-1:0]  sync_id
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CMD_W-1:0] cmd_mem [DEPTH];
    logic [DW-1:0]    sdo_mem [DEPTH];
    logic             cmd_we;
    logic             sdo_we;

    assign cmd_we = ld_cmd_valid & ~lock & (cmd_cnt < FULL);
    assign sdo_we = ld_sdo_valid & ~lock & (sdo_cnt < FULL);

    always_ff @(posedge clk) begin
        if (cmd_we) cmd_mem[cmd_cnt[AW-1:0]] <= ld_cmd_data;
        if (sdo_we) sdo_mem[sdo_cnt[AW-1:0]] <= ld_sdo_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_cnt <= '0;
            sdo_cnt <= '0;
            sync_id <= '0;
        end else begin
            if (cmd_we) cmd_cnt <= cmd_cnt + 1'b1;
            if (sdo_we) sdo_cnt <= sdo_cnt + 1'b1;
            if (id_inc)
                sync_id <= sync_id + 1'b1;
            else if (cmd_we && cmd_is_sync(ld_cmd_data))
                sync_id <= ld_cmd_data[ID_W-1:0];
        end
    end

    assign cmd_word = cmd_mem[cmd_idx];
    assign sdo_word = sdo_mem[sdo_idx];

    // R1
    load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(cmd_cnt) && $stable(sdo_cnt)));

    // R9
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_inc |=> (sync_id == $past(sync_id) + 1'b1));

endmodule

// File: rtl/replay_fsm.sv
module replay_fsm
    import spi_replay_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          trig_rise,
    input  logic          dma_ready,
    input  logic [CW-1:0] cmd_cnt,
    input  logic [CW-1:0] sdo_cnt,
    input  logic          cmd_ready,
    input  logic          sdo_ready,
    output logic          active,
    output logic          cmd_valid,
    output logic          sdo_valid,
    output logic [AW-1:0] cmd_idx,
    output logic [AW-1:0] sdo_idx,
    output logic          finish
);

    rep_state_t    state_q, state_d;
    logic [CW-1:0] cmd_ptr_q;
    logic [CW-1:0] sdo_ptr_q;
    logic          cmd_left, sdo_left;
    logic          cmd_fire, sdo_fire;
    logic          cmd_done, sdo_done;
    logic          start;

    assign cmd_left = cmd_ptr_q < cmd_cnt;
    assign sdo_left = sdo_ptr_q < sdo_cnt;
    assign cmd_fire = cmd_valid & cmd_ready;
    assign sdo_fire = sdo_valid & sdo_ready;
    assign cmd_done = ~cmd_left | (cmd_fire & (cmd_ptr_q + 1'b1 == cmd_cnt));
    assign sdo_done = ~sdo_left | (sdo_fire & (sdo_ptr_q + 1'b1 == sdo_cnt));
    assign start    = en & trig_rise & dma_ready & (cmd_cnt != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  if (cmd_done && sdo_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ptr_q <= '0;
            sdo_ptr_q <= '0;
        end else if (state_q == ST_ISSUE) begin
            if (cmd_fire) cmd_ptr_q <= cmd_ptr_q + 1'b1;
            if (sdo_fire) sdo_ptr_q <= sdo_ptr_q + 1'b1;
        end else begin
            cmd_ptr_q <= '0;
            sdo_ptr_q <= '0;
        end
    end

    always_comb begin
        active    = 1'b0;
        cmd_valid = 1'b0;
        sdo_valid = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                active    = 1'b1;
                cmd_valid = cmd_left;
                sdo_valid = sdo_left;
            end
            ST_FINISH: begin
                active = 1'b1;
                finish = 1'b1;
            end
            default: ;
        endcase
    end

    assign cmd_idx = cmd_ptr_q[AW-1:0];
    assign sdo_idx = sdo_ptr_q[AW-1:0];

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(dma_ready) && $past(en)));

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_idx)));

    // R3
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) |-> (cmd_ptr_q <= cmd_cnt && sdo_ptr_q <= sdo_cnt));

endmodule

// File: rtl/spi_replay_seq.sv
module spi_replay_seq
    import spi_replay_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int DW         = 8,
    parameter bit ASYNC_TRIG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig_in,
    input  logic             ld_cmd_valid,
    input  logic [CMD_W-1:0] ld_cmd_data,
    input  logic             ld_sdo_valid,
    input  logic [DW-1:0]    ld_sdo_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CMD_W-1:0] cmd_data,
    output logic             sdo_valid,
    input  logic             sdo_ready,
    output logic [DW-1:0]    sdo_data,
    input  logic             sdi_valid,
    output logic             sdi_ready,
    input  logic [DW-1:0]    sdi_data,
    output logic             dma_valid,
    input  logic             dma_ready,
    output logic [DW-1:0]    dma_data,
    output logic             stat_valid,
    input  logic             stat_ready,
    output logic [ID_W-1:0]  stat_id
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          trig_rise;
    logic          active;
    logic          finish;
    logic [AW-1:0] cmd_idx, sdo_idx;
    logic [CW-1:0] cmd_cnt, sdo_cnt;
    logic [ID_W-1:0] sync_id;

    replay_trig_detect #(.ASYNC_TRIG(ASYNC_TRIG)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    replay_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock         (en | active),
        .ld_cmd_valid (ld_cmd_valid),
        .ld_cmd_data  (ld_cmd_data),
        .ld_sdo_valid (ld_sdo_valid),
        .ld_sdo_data  (ld_sdo_data),
        .cmd_idx      (cmd_idx),
        .sdo_idx      (sdo_idx),
        .id_inc       (finish),
        .cmd_word     (cmd_data),
        .sdo_word     (sdo_data),
        .cmd_cnt      (cmd_cnt),
        .sdo_cnt      (sdo_cnt),
        .sync_id      (sync_id)
    );

    replay_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .trig_rise (trig_rise),
        .dma_ready (dma_ready),
        .cmd_cnt   (cmd_cnt),
        .sdo_cnt   (sdo_cnt),
        .cmd_ready (cmd_ready),
        .sdo_ready (sdo_ready),
        .active    (active),
        .cmd_valid (cmd_valid),
        .sdo_valid (sdo_valid),
        .cmd_idx   (cmd_idx),
        .sdo_idx   (sdo_idx),
        .finish    (finish)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_id    <= '0;
        end else if (finish) begin
            stat_valid <= 1'b1;
            stat_id    <= sync_id;
        end else if (stat_ready) begin
            stat_valid <= 1'b0;
        end
    end

    assign dma_valid = active & sdi_valid;
    assign dma_data  = sdi_data;
    assign sdi_ready = active ? dma_ready : 1'b1;

    // R9
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_ready) |=> stat_valid);

    // R10
    idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid && !sdo_valid && !dma_valid && !stat_valid |-> sdi_ready || active);

endmodule

// File: tb/spi_replay_seq_tb.sv
module spi_replay_seq_tb;

    localparam int DEPTH = 16;
    localparam int DW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, trig_in = 1'b0;
    logic ld_cmd_valid = 1'b0, ld_sdo_valid = 1'b0;
    logic [15:0] ld_cmd_data = '0;
    logic [DW-1:0] ld_sdo_data = '0;
    logic cmd_valid, sdo_valid, sdi_ready, dma_valid, stat_valid;
    logic cmd_ready = 1'b1, sdo_ready = 1'b1;
    logic [15:0] cmd_data;
    logic [DW-1:0] sdo_data, dma_data;
    logic sdi_valid = 1'b0, dma_ready = 1'b1, stat_ready = 1'b0;
    logic [DW-1:0] sdi_data = '0;
    logic [7:0] stat_id;

    always #10 clk = ~clk;

    spi_replay_seq #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .trig_in(trig_in),
        .ld_cmd_valid(ld_cmd_valid), .ld_cmd_data(ld_cmd_data),
        .ld_sdo_valid(ld_sdo_valid), .ld_sdo_data(ld_sdo_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
        .sdi_valid(sdi_valid), .sdi_ready(sdi_ready), .sdi_data(sdi_data),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data),
        .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_id(stat_id)
    );

    int total = 0, fails = 0;
    int rmode = 0;  // 0 ready high, 1 random, 2 stalled

    logic [15:0]   cmd_log [2048];
    logic [DW-1:0] sdo_log [2048];
    int cmd_total = 0, sdo_total = 0, cbase = 0, sbase = 0;

    logic [15:0]   exp_cmd [DEPTH];
    logic [DW-1:0] exp_sdo [DEPTH];
    int exp_cmd_n = 0, exp_sdo_n = 0;
    logic [7:0] exp_id = '0;

    always @(posedge clk) begin
        if (cmd_valid && cmd_ready) begin cmd_log[cmd_total] <= cmd_data; cmd_total <= cmd_total + 1; end
        if (sdo_valid && sdo_ready) begin sdo_log[sdo_total] <= sdo_data; sdo_total <= sdo_total + 1; end
    end

    always @(negedge clk) begin
        if (rmode == 1) begin
            cmd_ready <= 1'($urandom % 2);
            sdo_ready <= 1'($urandom % 2);
        end else begin
            cmd_ready <= (rmode == 0);
            sdo_ready <= (rmode == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_sync(input logic [15:0] c);
        return c[15:12] == 4'h3;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cmd_n = 0; exp_sdo_n = 0; exp_id = '0;
        @(negedge clk);
    endtask

    task automatic load_cmd(input logic [15:0] c);
        ld_cmd_valid = 1'b1; ld_cmd_data = c;
        @(negedge clk);
        ld_cmd_valid = 1'b0;
        if (!en && exp_cmd_n < DEPTH) begin
            exp_cmd[exp_cmd_n] = c; exp_cmd_n++;
            if (is_sync(c)) exp_id = c[7:0];
        end
    endtask

    task automatic load_sdo(input logic [DW-1:0] d);
        ld_sdo_valid = 1'b1; ld_sdo_data = d;
        @(negedge clk);
        ld_sdo_valid = 1'b0;
        if (!en && exp_sdo_n < DEPTH) begin
            exp_sdo[exp_sdo_n] = d; exp_sdo_n++;
        end
    endtask

    task automatic mark();
        cbase = cmd_total; sbase = sdo_total;
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        repeat (4) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic finish_check(input string req);
        int t = 0;
        bit ok;
        while (!stat_valid && t < 3000) begin @(negedge clk); t++; end
        chk(stat_valid, {req, " status posted"}, stat_valid, 1);
        chk(cmd_total - cbase == exp_cmd_n, {req, " R3 command count"}, cmd_total - cbase, exp_cmd_n);
        ok = 1;
        for (int i = 0; i < exp_cmd_n; i++) if (cmd_log[cbase + i] !== exp_cmd[i]) ok = 0;
        chk(ok, {req, " R3 command order"}, ok, 1);
        chk(sdo_total - sbase == exp_sdo_n, {req, " R4 data count"}, sdo_total - sbase, exp_sdo_n);
        ok = 1;
        for (int i = 0; i < exp_sdo_n; i++) if (sdo_log[sbase + i] !== exp_sdo[i]) ok = 0;
        chk(ok, {req, " R4 data order"}, ok, 1);
        chk(stat_id == exp_id, {req, " R9 stat_id"}, stat_id, exp_id);
        exp_id++;
        @(negedge clk);
        chk(stat_valid, {req, " R9 status held"}, stat_valid, 1);
        stat_ready = 1'b1;
        @(negedge clk);
        stat_ready = 1'b0;
        chk(!stat_valid, {req, " R9 status cleared"}, stat_valid, 0);
    endtask

    task automatic replay(input string req);
        mark();
        pulse_trig();
        finish_check(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R2 reset state
        chk(!cmd_valid && !sdo_valid && !stat_valid, "R2 reset outputs", {cmd_valid, sdo_valid, stat_valid}, 0);
        chk(sdi_ready && !dma_valid, "R2 idle read path", {sdi_ready, dma_valid}, 2'b10);
        en = 1'b1; mark(); pulse_trig(); repeat (10) @(negedge clk);
        chk(cmd_total == cbase && !stat_valid, "R2 empty store no replay", cmd_total - cbase, 0);

        // R8 directed list with two SYNC commands, last wins
        en = 1'b0;
        load_cmd(16'h1234); load_cmd(16'h3055); load_cmd(16'h2001); load_cmd(16'h3042);
        load_sdo(8'hA1); load_sdo(8'hB2);
        chk(exp_id == 8'h42, "R8 model last SYNC", exp_id, 8'h42);
        en = 1'b1;
        // R12 trigger latency through the synchronizer
        mark();
        trig_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!cmd_valid, "R12 no command before third edge", cmd_valid, 0);
        @(negedge clk);
        chk(cmd_valid, "R12 command at third edge", cmd_valid, 1);
        @(negedge clk); trig_in = 1'b0;
        finish_check("R8 first replay");
        replay("R9 second replay");

        // R5 DMA not ready
        dma_ready = 1'b0; mark(); pulse_trig(); repeat (10) @(negedge clk);
        chk(cmd_total == cbase && !cmd_valid, "R5 trigger ignored without dma_ready", cmd_total - cbase, 0);
        dma_ready = 1'b1; repeat (3) @(negedge clk);

        // R11 stall, R6 second trigger, R10 read path
        rmode = 2; mark(); pulse_trig();
        begin
            logic [15:0] first;
            first = cmd_data;
            chk(cmd_valid, "R11 valid while stalled", cmd_valid, 1);
            repeat (5) @(negedge clk);
            chk(cmd_valid && cmd_data == first && cmd_data == exp_cmd[0], "R11 stable while stalled", cmd_data, exp_cmd[0]);
            chk(cmd_total == cbase, "R11 no advance without ready", cmd_total - cbase, 0);
        end
        pulse_trig();
        sdi_valid = 1'b1; sdi_data = 8'h5A; dma_ready = 1'b0; #1;
        chk(!sdi_ready && dma_valid && dma_data == 8'h5A, "R10 active pass-through, dma stalled", {sdi_ready, dma_valid, dma_data}, {2'b01, 8'h5A});
        dma_ready = 1'b1; #1;
        chk(sdi_ready, "R10 active ready follows dma", sdi_ready, 1);
        @(negedge clk);
        rmode = 0;
        finish_check("R6 single replay after retrigger");
        repeat (20) @(negedge clk);
        chk(cmd_total == cbase + exp_cmd_n && !stat_valid, "R6 no queued replay", cmd_total - cbase, exp_cmd_n);
        dma_ready = 1'b0; #1;
        chk(sdi_ready && !dma_valid, "R10 idle drains read data", {sdi_ready, dma_valid}, 2'b10);
        sdi_valid = 1'b0; dma_ready = 1'b1;

        // R7 enable dropped mid-replay
        rmode = 2; mark(); pulse_trig();
        en = 1'b0; repeat (3) @(negedge clk);
        rmode = 0;
        finish_check("R7 replay completes after en low");
        mark(); pulse_trig(); repeat (10) @(negedge clk);
        chk(cmd_total == cbase, "R7 no start with en low", cmd_total - cbase, 0);

        // R1 loads while enabled are ignored
        en = 1'b1;
        load_cmd(16'h3077); load_sdo(8'hEE);
        replay("R1 list unchanged after enabled loads");

        // R1 overflow
        do_reset();
        for (int i = 0; i < DEPTH + 3; i++) load_cmd(16'h1000 + 16'(i));
        chk(exp_cmd_n == DEPTH, "R1 model depth", exp_cmd_n, DEPTH);
        en = 1'b1;
        replay("R1 overflow ignored");

        // random rounds
        for (int r = 0; r < 6; r++) begin
            int n, m;
            do_reset();
            n = 1 + int'($urandom % DEPTH);
            m = int'($urandom % (DEPTH + 1));
            for (int i = 0; i < n; i++) load_cmd(16'($urandom));
            for (int i = 0; i < m; i++) load_sdo(DW'($urandom));
            en = 1'b1;
            rmode = 1;
            replay("R3 random replay");
            replay("R4 random replay again");
            rmode = 0;
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule